// File: doc/BRIEF.md
# Stop-Recovery and Low-Voltage Gating Controller

This block sits next to the core of a small microcontroller and owns an 8-bit configuration register. The register selects the watchdog timeout, controls the low-voltage detector and picks the stop-recovery length. When the core leaves stop mode, the block counts a stabilization delay on the oscillator clock. When the delay ends, it sends the core a one-cycle resume strobe.

The block also decides whether the low-voltage detector is powered, both while running and while stopped. It brings the detector's asynchronous trip flag into the clock domain through two flops. It then raises a reset request only when the detector is enabled and its reset path is allowed.

A wake caused by reset always takes the long delay, whatever the register holds. While stopped, the detector stays alive only if the stop-enable bit is set and the power-off bit is clear.

Top module: `stoprec_lvi_ctrl`

## Requirements
- R1: After reset, the register reads 0x00, resume_o is 0, lvi_en_o is 1, lvi_rst_req_o is 0 and wdog_period_o is 262128.
- R2: A write stores bits 7..4 and 2..0 of wr_data_i, and rd_data_o shows them in the next cycle. Bit 3 is unused: it always reads 0 and ignores writes.
- R3: wdog_period_o is 8176 when register bit 7 is 1 and 262128 when it is 0.
- R4: Bit 2 selects short recovery. When bit 2 is 1 and the wake is not reset-caused, resume_o is high in the cycle after the 32nd rising edge that follows the edge sampling wake_req_i.
- R5: When bit 2 is 0, that count is 4096 edges instead of 32.
- R6: A wake with wake_by_rst_i = 1 always uses the 4096-edge recovery, even when bit 2 is 1.
- R7: resume_o is a pulse that lasts exactly one clock cycle.
- R8: wake_req_i has no effect while a recovery count is running, and no effect while the core is running.
- R9: stop_enter_i is accepted only while running, that is after the resume strobe. A stop request made during recovery is dropped.
- R10: lvi_en_o is 0 whenever bit 4 is 1. From the edge that accepts a stop until resume, lvi_en_o is 1 only when bit 6 is 1 and bit 4 is 0.
- R11: lvi_trip_i passes through a two-flop synchronizer, so lvi_rst_req_o follows it after two rising edges. The request is held at 0 when bit 5 is 1 or when lvi_en_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register contents |
| stop_enter_i | input | 1 | Core enters stop mode |
| wake_req_i | input | 1 | Request to leave stop mode |
| wake_by_rst_i | input | 1 | The wake is caused by reset |
| lvi_trip_i | input | 1 | Asynchronous low-voltage comparator flag |
| resume_o | output | 1 | One-cycle CPU resume strobe |
| lvi_en_o | output | 1 | Low-voltage detector enable |
| lvi_rst_req_o | output | 1 | Low-voltage reset request |
| wdog_period_o | output | 18 | Selected watchdog timeout in reference cycles |

## Verification
The block has no status output for its stop phase, so the hardest cases to reach are those that happen inside a recovery: a second wake, or a stop request while the count is running. The stimulus clears bit 6 so that lvi_en_o shows whether the block is stopped or running. It then injects the stray wake or stop partway through a short recovery. Finally it checks two things at the ports: the resume edge count is unchanged, and lvi_en_o returns to 1 after the strobe.

// File: rtl/stoprec_pkg.sv
package stoprec_pkg;

    typedef enum logic [1:0] {
        PH_RUN     = 2'd0,
        PH_STOPPED = 2'd1,
        PH_RECOVER = 2'd2
    } phase_e;

    typedef struct packed {
        logic cop_fast;
        logic det_in_stop;
        logic det_rst_off;
        logic det_pwr_off;
        logic unused3;
        logic quick_rec;
        logic stop_ok;
        logic cop_off;
    } cfg_t;

    localparam logic [7:0] CFG_WR_MASK = 8'b1111_0111;

endpackage

// File: rtl/srl_cfg_reg.sv
module srl_cfg_reg
    import stoprec_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       wr_en_i,
    input  logic [7:0] wr_data_i,
    output logic [7:0] rd_data_o,
    output logic       cop_fast_o,
    output logic       det_in_stop_o,
    output logic       det_rst_off_o,
    output logic       det_pwr_off_o,
    output logic       quick_rec_o
);

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en_i) begin
            cfg_d = cfg_t'(wr_data_i & CFG_WR_MASK);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign rd_data_o     = cfg_q;
    assign cop_fast_o    = cfg_q.cop_fast;
    assign det_in_stop_o = cfg_q.det_in_stop;
    assign det_rst_off_o = cfg_q.det_rst_off;
    assign det_pwr_off_o = cfg_q.det_pwr_off;
    assign quick_rec_o   = cfg_q.quick_rec;

endmodule

// File: rtl/srl_rec_timer.sv
module srl_rec_timer
    import stoprec_pkg::*;
#(
    parameter int SHORT_CYC = 32,
    parameter int LONG_CYC  = 4096
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic stop_enter_i,
    input  logic wake_req_i,
    input  logic wake_by_rst_i,
    input  logic quick_rec_i,
    output logic resume_o,
    output logic in_stop_o
);

    localparam int CNT_W = $clog2(LONG_CYC);
    localparam logic [CNT_W-1:0] LONG_LIM  = CNT_W'(LONG_CYC - 1);
    localparam logic [CNT_W-1:0] SHORT_LIM = CNT_W'(SHORT_CYC - 1);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic             long_sel;
        logic             resume;
    } tmr_t;

    tmr_t st_d, st_q;
    logic [CNT_W-1:0] limit;

    assign limit = st_q.long_sel ? LONG_LIM : SHORT_LIM;

    always_comb begin
        st_d        = st_q;
        st_d.resume = 1'b0;
        case (st_q.phase)
            PH_RUN: begin
                if (stop_enter_i) begin
                    st_d.phase = PH_STOPPED;
                end
            end
            PH_STOPPED: begin
                if (wake_req_i) begin
                    st_d.phase    = PH_RECOVER;
                    st_d.cnt      = '0;
                    st_d.long_sel = wake_by_rst_i | ~quick_rec_i;
                end
            end
            PH_RECOVER: begin
                if (st_q.cnt == limit) begin
                    st_d.phase  = PH_RUN;
                    st_d.cnt    = '0;
                    st_d.resume = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            default: begin
                st_d.phase = PH_RUN;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{phase: PH_RUN, cnt: '0, long_sel: 1'b1, resume: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign resume_o  = st_q.resume;
    assign in_stop_o = (st_q.phase != PH_RUN);

endmodule

// File: rtl/srl_lvi_gate.sv
module srl_lvi_gate #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic trip_i,
    input  logic in_stop_i,
    input  logic det_in_stop_i,
    input  logic det_rst_off_i,
    input  logic det_pwr_off_i,
    output logic lvi_en_o,
    output logic rst_req_o
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_d, sync_q;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_comb sync_d = trip_i;
        end else begin : g_many
            always_comb sync_d = {sync_q[SYNC_STAGES-2:0], trip_i};
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign lvi_en_o  = ~det_pwr_off_i & (~in_stop_i | det_in_stop_i);
    assign rst_req_o = sync_q[LAST] & lvi_en_o & ~det_rst_off_i;

endmodule

// File: rtl/stoprec_lvi_ctrl.sv
module stoprec_lvi_ctrl #(
    parameter int SHORT_CYC   = 32,
    parameter int LONG_CYC    = 4096,
    parameter int COP_SHORT   = 8176,
    parameter int COP_LONG    = 262128,
    parameter int SYNC_STAGES = 2,
    parameter int PER_W       = $clog2(COP_LONG + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_en_i,
    input  logic [7:0]       wr_data_i,
    output logic [7:0]       rd_data_o,
    input  logic             stop_enter_i,
    input  logic             wake_req_i,
    input  logic             wake_by_rst_i,
    input  logic             lvi_trip_i,
    output logic             resume_o,
    output logic             lvi_en_o,
    output logic             lvi_rst_req_o,
    output logic [PER_W-1:0] wdog_period_o
);

    logic cop_fast, det_in_stop, det_rst_off, det_pwr_off, quick_rec, in_stop;

    srl_cfg_reg u_cfg (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .wr_en_i       (wr_en_i),
        .wr_data_i     (wr_data_i),
        .rd_data_o     (rd_data_o),
        .cop_fast_o    (cop_fast),
        .det_in_stop_o (det_in_stop),
        .det_rst_off_o (det_rst_off),
        .det_pwr_off_o (det_pwr_off),
        .quick_rec_o   (quick_rec)
    );

    srl_rec_timer #(
        .SHORT_CYC (SHORT_CYC),
        .LONG_CYC  (LONG_CYC)
    ) u_tmr (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .stop_enter_i  (stop_enter_i),
        .wake_req_i    (wake_req_i),
        .wake_by_rst_i (wake_by_rst_i),
        .quick_rec_i   (quick_rec),
        .resume_o      (resume_o),
        .in_stop_o     (in_stop)
    );

    srl_lvi_gate #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_lvi (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .trip_i        (lvi_trip_i),
        .in_stop_i     (in_stop),
        .det_in_stop_i (det_in_stop),
        .det_rst_off_i (det_rst_off),
        .det_pwr_off_i (det_pwr_off),
        .lvi_en_o      (lvi_en_o),
        .rst_req_o     (lvi_rst_req_o)
    );

    assign wdog_period_o = cop_fast ? PER_W'(COP_SHORT) : PER_W'(COP_LONG);

endmodule

// File: rtl/stoprec_lvi_chk.sv
module stoprec_lvi_chk #(
    parameter int COP_SHORT = 8176,
    parameter int COP_LONG  = 262128,
    parameter int PER_W     = 18
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [7:0]       rd_data_o,
    input logic             lvi_trip_i,
    input logic             resume_o,
    input logic             lvi_en_o,
    input logic             lvi_rst_req_o,
    input logic [PER_W-1:0] wdog_period_o
);

    AST_RESUME_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        resume_o |=> !resume_o); // R7

    AST_UNUSED_BIT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_data_o[3]); // R2

    AST_PERIOD_FAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_data_o[7] |-> (wdog_period_o == PER_W'(COP_SHORT))); // R3

    AST_PERIOD_SLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_data_o[7] |-> (wdog_period_o == PER_W'(COP_LONG))); // R3

    AST_PWR_OFF_DISABLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_data_o[4] |-> !lvi_en_o); // R10

    AST_RST_OFF_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_data_o[5] |-> !lvi_rst_req_o); // R11

    AST_REQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lvi_rst_req_o |-> lvi_en_o); // R11

    AST_REQ_AFTER_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lvi_rst_req_o |-> $past(lvi_trip_i, 2)); // R11

endmodule

bind stoprec_lvi_ctrl stoprec_lvi_chk #(
    .COP_SHORT (COP_SHORT),
    .COP_LONG  (COP_LONG),
    .PER_W     (PER_W)
) chk_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .rd_data_o     (rd_data_o),
    .lvi_trip_i    (lvi_trip_i),
    .resume_o      (resume_o),
    .lvi_en_o      (lvi_en_o),
    .lvi_rst_req_o (lvi_rst_req_o),
    .wdog_period_o (wdog_period_o)
);

// File: tb/stoprec_lvi_ctrl_tb_top.sv
module stoprec_lvi_ctrl_tb_top;

    localparam int SHORT_CYC = 32;
    localparam int LONG_CYC  = 4096;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [7:0]  wr_data_i = '0;
    logic [7:0]  rd_data_o;
    logic        stop_enter_i = 1'b0;
    logic        wake_req_i = 1'b0;
    logic        wake_by_rst_i = 1'b0;
    logic        lvi_trip_i = 1'b0;
    logic        resume_o;
    logic        lvi_en_o;
    logic        lvi_rst_req_o;
    logic [17:0] wdog_period_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk_i = ~clk_i;

    stoprec_lvi_ctrl dut_i (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .wr_en_i       (wr_en_i),
        .wr_data_i     (wr_data_i),
        .rd_data_o     (rd_data_o),
        .stop_enter_i  (stop_enter_i),
        .wake_req_i    (wake_req_i),
        .wake_by_rst_i (wake_by_rst_i),
        .lvi_trip_i    (lvi_trip_i),
        .resume_o      (resume_o),
        .lvi_en_o      (lvi_en_o),
        .lvi_rst_req_o (lvi_rst_req_o),
        .wdog_period_o (wdog_period_o)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk_i);
            @(negedge clk_i);
        end
    endtask

    task automatic wr_cfg(input logic [7:0] v);
        wr_en_i = 1'b1;
        wr_data_i = v;
        cyc(1);
        wr_en_i = 1'b0;
    endtask

    task automatic enter_stop();
        stop_enter_i = 1'b1;
        cyc(1);
        stop_enter_i = 1'b0;
    endtask

    // Edges from the one that samples the wake up to the visible resume.
    // When stray_at > 0, one more wake is pulsed that many cycles later.
    task automatic wake_and_count(input logic by_rst, input int stray_at, output int n);
        wake_req_i = 1'b1;
        wake_by_rst_i = by_rst;
        n = 0;
        for (int i = 0; i < 6000; i++) begin
            @(posedge clk_i);
            n++;
            @(negedge clk_i);
            wake_req_i = (stray_at > 0 && n == stray_at);
            wake_by_rst_i = 1'b0;
            if (resume_o) break;
        end
        wake_req_i = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 cfg", rd_data_o, 0);
        chk("R1 resume", resume_o, 0);
        chk("R1 lvi_en", lvi_en_o, 1);
        chk("R1 rst_req", lvi_rst_req_o, 0);
        chk("R1 period", wdog_period_o, 262128);
    endtask

    task automatic t_regs();
        wr_cfg(8'hFF);
        chk("R2 all ones, bit3 dropped", rd_data_o, 8'hF7);
        wr_cfg(8'h08);
        chk("R2 bit3 only", rd_data_o, 8'h00);
        wr_cfg(8'h5A);
        chk("R2 pattern", rd_data_o, 8'h52);
        wr_cfg(8'h00);
    endtask

    task automatic t_period();
        wr_cfg(8'h80);
        chk("R3 fast period", wdog_period_o, 8176);
        wr_cfg(8'h00);
        chk("R3 slow period", wdog_period_o, 262128);
    endtask

    task automatic t_short();
        int n;
        wr_cfg(8'h04);
        enter_stop();
        wake_and_count(1'b0, 0, n);
        chk("R4 short recovery edges", n, SHORT_CYC + 1);
        cyc(1);
        chk("R7 resume drops", resume_o, 0);
    endtask

    task automatic t_long();
        int n;
        wr_cfg(8'h00);
        enter_stop();
        wake_and_count(1'b0, 0, n);
        chk("R5 long recovery edges", n, LONG_CYC + 1);
        cyc(1);
        chk("R7 resume drops long", resume_o, 0);
    endtask

    task automatic t_rst_wake();
        int n;
        wr_cfg(8'h04);
        enter_stop();
        wake_and_count(1'b1, 0, n);
        chk("R6 reset wake forces long", n, LONG_CYC + 1);
    endtask

    task automatic t_wake_ignored();
        int n;
        int seen;
        wr_cfg(8'h04);
        enter_stop();
        wake_and_count(1'b0, 10, n);
        chk("R8 wake during recovery", n, SHORT_CYC + 1);
        seen = 0;
        wake_req_i = 1'b1;
        for (int i = 0; i < 50; i++) begin
            cyc(1);
            wake_req_i = 1'b0;
            if (resume_o) seen++;
        end
        chk("R8 wake while running", seen, 0);
    endtask

    task automatic t_stop_ignored();
        int n;
        wr_cfg(8'h04);
        enter_stop();
        chk("R10 stopped, det off", lvi_en_o, 0);
        wake_req_i = 1'b1;
        cyc(1);
        wake_req_i = 1'b0;
        cyc(5);
        enter_stop();
        n = 0;
        for (int i = 0; i < 100; i++) begin
            cyc(1);
            n++;
            if (resume_o) break;
        end
        chk("R9 resume despite stop in recovery", resume_o, 1);
        cyc(1);
        chk("R9 running after resume", lvi_en_o, 1);
        cyc(20);
        chk("R9 still running", lvi_en_o, 1);
    endtask

    task automatic t_lvi_enable();
        int n;
        wr_cfg(8'h40);
        enter_stop();
        chk("R10 stop with det_in_stop", lvi_en_o, 1);
        wake_and_count(1'b0, 0, n);
        wr_cfg(8'h10);
        chk("R10 power off running", lvi_en_o, 0);
        wr_cfg(8'h50);
        enter_stop();
        chk("R10 power off overrides in stop", lvi_en_o, 0);
        wr_cfg(8'h54);
        wake_and_count(1'b0, 0, n);
        wr_cfg(8'h00);
        chk("R10 enabled running", lvi_en_o, 1);
    endtask

    task automatic t_trip();
        wr_cfg(8'h00);
        lvi_trip_i = 1'b1;
        cyc(1);
        chk("R11 one edge, no req", lvi_rst_req_o, 0);
        cyc(1);
        chk("R11 two edges, req", lvi_rst_req_o, 1);
        wr_cfg(8'h20);
        chk("R11 reset path disabled", lvi_rst_req_o, 0);
        wr_cfg(8'h10);
        chk("R11 detector unpowered", lvi_rst_req_o, 0);
        wr_cfg(8'h00);
        chk("R11 req back", lvi_rst_req_o, 1);
        lvi_trip_i = 1'b0;
        cyc(1);
        chk("R11 clear one edge", lvi_rst_req_o, 1);
        cyc(1);
        chk("R11 clear two edges", lvi_rst_req_o, 0);
    endtask

    initial begin
        cyc(3);
        rst_ni = 1'b1;
        cyc(1);
        t_reset();
        t_regs();
        t_period();
        t_short();
        t_long();
        t_rst_wake();
        t_wake_ignored();
        t_stop_ignored();
        t_lvi_enable();
        t_trip();
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 150000; i++) begin
            @(posedge clk_i);
            if (done) break;
        end
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule